// File: doc/BRIEF.md
# Configurable generic register cell

This block is a multi-bit edge-triggered register that can stand in for every member of a generic flip-flop family. One set of parameters picks the clock edge and turns on any of the optional controls: an asynchronous reset to a constant, a synchronous reset to a constant, an asynchronous load from a separate data bus, per-bit asynchronous force-high and force-low inputs, and a clock enable. When both the enable and the synchronous reset are present, a parameter decides which of them has priority.

Each control input has its own active-level parameter. All control pins are always present on the port list. A pin whose feature is turned off is read but has no effect. Elaboration stops with an error if more than one asynchronous feature is selected. It also stops if the synchronous reset is combined with any asynchronous feature, or if a polarity parameter is not 0 or 1.

The block is meant for netlist-level code that needs one parameterized register primitive in place of a zoo of hand-written flops.

Top module: `cfg_flop`

## Requirements
- R1: With the enable active (or absent) and the synchronous reset inactive, the output takes `d_i` on the active clock edge.
- R2: `CLK_RISE`=1 makes the rising edge of `clk_i` active, and `CLK_RISE`=0 makes the falling edge active. The output does not change on the other edge.
- R3: Each control pin has its own level parameter. A value of 1 makes the pin active-high and 0 makes it active-low. For the force pins this applies to every bit.
- R4: While the asynchronous reset is active, the output equals `ARST_INIT` at once, without waiting for a clock edge, and stays there across clock edges. Once the reset is released, the next active edge loads data normally.
- R5: An active synchronous reset loads `SRST_INIT` on the active clock edge.
- R6: With `SRST_BEATS_CE`=1, the synchronous reset loads `SRST_INIT` even when the enable is inactive.
- R7: With `SRST_BEATS_CE`=0, the synchronous reset acts only when the enable is active. While the enable is inactive, the output holds even if the reset is active.
- R8: With the enable inactive and no reset, load or force active, the output holds its value across active clock edges.
- R9: While the asynchronous load is active, the output follows `ld_data_i` combinationally. After release, it keeps the value last taken from that bus, either at the load's assertion or at a clock edge during it, until the next active edge.
- R10: The force-low and force-high inputs act per bit and at once. Force-low wins when both are active on the same bit. Other bits are unaffected. A forced bit keeps its value after release until the next active edge.
- R11: The pins of a feature that is turned off have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the active edge is chosen by `CLK_RISE` |
| d_i | input | WIDTH | Data captured on the active edge |
| q_o | output | WIDTH | Register output |
| arst_i | input | 1 | Asynchronous reset, level set by `ARST_HIGH` |
| srst_i | input | 1 | Synchronous reset, level set by `SRST_HIGH` |
| ld_i | input | 1 | Asynchronous load enable, level set by `LOAD_HIGH` |
| ld_data_i | input | WIDTH | Data shown and stored while the load is active |
| force_hi_i | input | WIDTH | Per-bit asynchronous force to 1, level set by `FHI_HIGH` |
| force_lo_i | input | WIDTH | Per-bit asynchronous force to 0, level set by `FLO_HIGH` |
| ce_i | input | 1 | Clock enable, level set by `CE_HIGH` |

## Verification
A wrong stored bit shows at `q_o` right after the next active edge, as long as no force is active, because the output is the register itself. The exception is an asynchronous control, which masks the stored value until it is released. A wrong next-state choice shows within one active edge: a reset or enable priority that is swapped, or a hold that captures. A forced path that picks the wrong value shows without any clock edge at all. A stale stored value under a force only appears at the first active edge after release, so the bench always checks across that edge. Every polarity setting and both enable-priority variants are driven, and two variants are compared with an in-bench reference model on every cycle.

// File: rtl/cfg_flop_pkg.sv
package cfg_flop_pkg;

  // Which asynchronous feature drives the per-bit force path.
  typedef enum logic [1:0] {
    FRC_NONE   = 2'd0,
    FRC_ARST   = 2'd1,
    FRC_LOAD   = 2'd2,
    FRC_SETCLR = 2'd3
  } frc_kind_e;

  function automatic int count_async(input int use_arst, input int use_load,
                                     input int use_force);
    return ((use_arst != 0) ? 1 : 0) + ((use_load != 0) ? 1 : 0) +
           ((use_force != 0) ? 1 : 0);
  endfunction

  function automatic frc_kind_e pick_kind(input int use_arst, input int use_load,
                                          input int use_force);
    if (use_arst != 0)  return FRC_ARST;
    if (use_load != 0)  return FRC_LOAD;
    if (use_force != 0) return FRC_SETCLR;
    return FRC_NONE;
  endfunction

  function automatic bit pol_ok(input int p);
    return (p == 0) || (p == 1);
  endfunction

endpackage

// File: rtl/cfg_flop_ctl.sv
// Normalizes every control pin to active-high, gates it by its feature
// switch and folds all asynchronous features into one per-bit force path.
module cfg_flop_ctl
  import cfg_flop_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter int               USE_ARST  = 0,
  parameter int               ARST_HIGH = 1,
  parameter logic [WIDTH-1:0] ARST_INIT = '0,
  parameter int               USE_SRST  = 0,
  parameter int               SRST_HIGH = 1,
  parameter int               USE_LOAD  = 0,
  parameter int               LOAD_HIGH = 1,
  parameter int               USE_FORCE = 0,
  parameter int               FHI_HIGH  = 1,
  parameter int               FLO_HIGH  = 1,
  parameter int               USE_CE    = 0,
  parameter int               CE_HIGH   = 1
) (
  input  logic             arst_i,
  input  logic             srst_i,
  input  logic             ld_i,
  input  logic [WIDTH-1:0] ld_data_i,
  input  logic [WIDTH-1:0] force_hi_i,
  input  logic [WIDTH-1:0] force_lo_i,
  input  logic             ce_i,
  output logic [WIDTH-1:0] frc_o,
  output logic [WIDTH-1:0] fval_o,
  output logic             srst_act_o,
  output logic             ce_act_o,
  output logic             async_act_o
);

  localparam int        NASYNC = count_async(USE_ARST, USE_LOAD, USE_FORCE);
  localparam frc_kind_e KIND   = pick_kind(USE_ARST, USE_LOAD, USE_FORCE);
  localparam bit        POLS_OK = pol_ok(ARST_HIGH) && pol_ok(SRST_HIGH) &&
                                  pol_ok(LOAD_HIGH) && pol_ok(FHI_HIGH) &&
                                  pol_ok(FLO_HIGH) && pol_ok(CE_HIGH);

  // Elaboration-time legality checks.
  if (NASYNC > 1) begin : g_err_multi_async
    $error("cfg_flop: at most one asynchronous feature may be selected");
  end
  if ((USE_SRST != 0) && (KIND != FRC_NONE)) begin : g_err_sync_async
    $error("cfg_flop: synchronous reset cannot be mixed with an asynchronous feature");
  end
  if (!POLS_OK) begin : g_err_pol
    $error("cfg_flop: polarity parameters must be 0 or 1");
  end

  // Active-high views of the pins.
  logic             arst_h, srst_h, ld_h, ce_h;
  logic [WIDTH-1:0] fhi_h, flo_h;

  assign arst_h = (ARST_HIGH != 0) ? arst_i : ~arst_i;
  assign srst_h = (SRST_HIGH != 0) ? srst_i : ~srst_i;
  assign ld_h   = (LOAD_HIGH != 0) ? ld_i   : ~ld_i;
  assign ce_h   = (CE_HIGH   != 0) ? ce_i   : ~ce_i;
  assign fhi_h  = (FHI_HIGH  != 0) ? force_hi_i : ~force_hi_i;
  assign flo_h  = (FLO_HIGH  != 0) ? force_lo_i : ~force_lo_i;

  // Gated by the feature switches: a disabled feature never becomes active.
  logic             arst_q, ld_q;
  logic [WIDTH-1:0] fhi_q, flo_q;

  assign arst_q = (USE_ARST  != 0) & arst_h;
  assign ld_q   = (USE_LOAD  != 0) & ld_h;
  assign fhi_q  = {WIDTH{USE_FORCE != 0}} & fhi_h;
  assign flo_q  = {WIDTH{USE_FORCE != 0}} & flo_h;

  // Per-bit force path; force-low wins over force-high.
  always_comb begin
    frc_o = {WIDTH{arst_q}} | {WIDTH{ld_q}} | fhi_q | flo_q;
    if (arst_q) begin
      fval_o = ARST_INIT;
    end else if (ld_q) begin
      fval_o = ld_data_i;
    end else begin
      fval_o = ~flo_q;
    end
  end

  assign srst_act_o  = (USE_SRST != 0) & srst_h;
  assign ce_act_o    = (USE_CE == 0) | ce_h;
  assign async_act_o = |frc_o;

endmodule

// File: rtl/cfg_flop_next.sv
// Synchronous next-state selection: enable, synchronous reset and hold,
// with the reset/enable priority chosen by a parameter.
module cfg_flop_next #(
  parameter int               WIDTH         = 8,
  parameter int               SRST_BEATS_CE = 1,
  parameter logic [WIDTH-1:0] SRST_INIT     = '0
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] q_i,
  input  logic             srst_act_i,
  input  logic             ce_act_i,
  input  logic             async_act_i,
  output logic [WIDTH-1:0] nxt_o
);

  if (SRST_BEATS_CE != 0) begin : g_rst_first
    always_comb begin
      if (srst_act_i) begin
        nxt_o = SRST_INIT;
      end else if (ce_act_i) begin
        nxt_o = d_i;
      end else begin
        nxt_o = q_i;
      end
    end

    // Reset acts regardless of the enable.
    assert_rst_over_ce_R6: assert property (@(posedge clk_i) disable iff (async_act_i)
      (srst_act_i && !async_act_i) |=> (async_act_i || (q_i == SRST_INIT)));
  end else begin : g_ce_first
    always_comb begin
      if (ce_act_i) begin
        nxt_o = srst_act_i ? SRST_INIT : d_i;
      end else begin
        nxt_o = q_i;
      end
    end

    // Reset is gated by the enable.
    assert_ce_gates_rst_R7: assert property (@(posedge clk_i) disable iff (async_act_i)
      (srst_act_i && !ce_act_i && !async_act_i) |=> (async_act_i || $stable(q_i)));
  end

  assert_capture_R1: assert property (@(posedge clk_i) disable iff (async_act_i)
    (ce_act_i && !srst_act_i && !async_act_i) |=> (async_act_i || (q_i == $past(d_i))));

  assert_srst_load_R5: assert property (@(posedge clk_i) disable iff (async_act_i)
    (ce_act_i && srst_act_i && !async_act_i) |=> (async_act_i || (q_i == SRST_INIT)));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (async_act_i)
    (!ce_act_i && !srst_act_i && !async_act_i) |=> (async_act_i || $stable(q_i)));

endmodule

// File: rtl/cfg_flop_store.sv
// One storage bit per data bit, each with its own asynchronous force input.
module cfg_flop_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] frc_i,
  input  logic [WIDTH-1:0] fval_i,
  input  logic [WIDTH-1:0] nxt_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic bit_r;

    always_ff @(posedge clk_i or posedge frc_i[b]) begin
      if (frc_i[b]) begin
        bit_r <= fval_i[b];
      end else begin
        bit_r <= nxt_i[b];
      end
    end

    // A level-sensitive force is shown at once, not only at its edge.
    assign q_o[b] = frc_i[b] ? fval_i[b] : bit_r;
  end

endmodule

// File: rtl/cfg_flop.sv
module cfg_flop
  import cfg_flop_pkg::*;
#(
  parameter int               WIDTH         = 8,
  parameter int               CLK_RISE      = 1,
  parameter int               USE_ARST      = 0,
  parameter int               ARST_HIGH     = 1,
  parameter logic [WIDTH-1:0] ARST_INIT     = '0,
  parameter int               USE_SRST      = 0,
  parameter int               SRST_HIGH     = 1,
  parameter logic [WIDTH-1:0] SRST_INIT     = '0,
  parameter int               USE_LOAD      = 0,
  parameter int               LOAD_HIGH     = 1,
  parameter int               USE_FORCE     = 0,
  parameter int               FHI_HIGH      = 1,
  parameter int               FLO_HIGH      = 1,
  parameter int               USE_CE        = 0,
  parameter int               CE_HIGH       = 1,
  parameter int               SRST_BEATS_CE = 1
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  input  logic             arst_i,
  input  logic             srst_i,
  input  logic             ld_i,
  input  logic [WIDTH-1:0] ld_data_i,
  input  logic [WIDTH-1:0] force_hi_i,
  input  logic [WIDTH-1:0] force_lo_i,
  input  logic             ce_i
);

  localparam logic CLK_INV = (CLK_RISE == 0);

  logic             clk_e;
  logic [WIDTH-1:0] frc, fval, nxt;
  logic             srst_act, ce_act, async_act;

  // Edge selection: the internal logic always works on the rising edge.
  assign clk_e = clk_i ^ CLK_INV;

  cfg_flop_ctl #(
    .WIDTH(WIDTH), .USE_ARST(USE_ARST), .ARST_HIGH(ARST_HIGH),
    .ARST_INIT(ARST_INIT), .USE_SRST(USE_SRST), .SRST_HIGH(SRST_HIGH),
    .USE_LOAD(USE_LOAD), .LOAD_HIGH(LOAD_HIGH), .USE_FORCE(USE_FORCE),
    .FHI_HIGH(FHI_HIGH), .FLO_HIGH(FLO_HIGH), .USE_CE(USE_CE),
    .CE_HIGH(CE_HIGH)
  ) u_ctl (
    .arst_i      (arst_i),
    .srst_i      (srst_i),
    .ld_i        (ld_i),
    .ld_data_i   (ld_data_i),
    .force_hi_i  (force_hi_i),
    .force_lo_i  (force_lo_i),
    .ce_i        (ce_i),
    .frc_o       (frc),
    .fval_o      (fval),
    .srst_act_o  (srst_act),
    .ce_act_o    (ce_act),
    .async_act_o (async_act)
  );

  cfg_flop_next #(
    .WIDTH(WIDTH), .SRST_BEATS_CE(SRST_BEATS_CE), .SRST_INIT(SRST_INIT)
  ) u_next (
    .clk_i       (clk_e),
    .d_i         (d_i),
    .q_i         (q_o),
    .srst_act_i  (srst_act),
    .ce_act_i    (ce_act),
    .async_act_i (async_act),
    .nxt_o       (nxt)
  );

  cfg_flop_store #(
    .WIDTH(WIDTH)
  ) u_store (
    .clk_i  (clk_e),
    .frc_i  (frc),
    .fval_i (fval),
    .nxt_i  (nxt),
    .q_o    (q_o)
  );

  // Asynchronous behaviour, sampled mid-cycle straight from the pins.
  if (USE_ARST != 0) begin : g_chk_arst
    always @(negedge clk_e) begin
      if (arst_i == (ARST_HIGH != 0)) begin
        assert_arst_value_R4: assert (q_o == ARST_INIT);
      end
    end
  end

  if (USE_LOAD != 0) begin : g_chk_load
    always @(negedge clk_e) begin
      if (ld_i == (LOAD_HIGH != 0)) begin
        assert_load_follow_R9: assert (q_o == ld_data_i);
      end
    end
  end

  if (USE_FORCE != 0) begin : g_chk_force
    for (genvar b = 0; b < WIDTH; b++) begin : g_fb
      always @(negedge clk_e) begin
        if (force_lo_i[b] == (FLO_HIGH != 0)) begin
          assert_lo_wins_R10: assert (q_o[b] == 1'b0);
        end else if (force_hi_i[b] == (FHI_HIGH != 0)) begin
          assert_hi_bit_R10: assert (q_o[b] == 1'b1);
        end
      end
    end
  end

endmodule

// File: tb/test_cfg_flop.sv
module test_cfg_flop;

  logic clk;
  int   total = 0;
  int   bad   = 0;
  bit   finished = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  // A: rising edge, sync reset beats enable, active-high pins; unused pins driven
  logic [7:0] a_d, a_ad, a_set, a_clr, q_a;
  logic       a_en, a_srst, a_arst, a_ald;
  // B: falling edge, enable gates sync reset, active-low enable and reset
  logic [7:0] b_d, q_b;
  logic       b_en, b_srst;
  // C: async reset, active-low
  logic [7:0] c_d, q_c;
  logic       c_en, c_arst;
  // D: async load, active-high, no enable
  logic [7:0] dd_d, d_ad, q_d;
  logic       d_ald;
  // E: per-bit forces, force-high active-high, force-low active-low, enable
  logic [7:0] e_d, e_set, e_clr, q_e;
  logic       e_en;

  cfg_flop #(.WIDTH(8), .USE_SRST(1), .SRST_HIGH(1), .SRST_INIT(8'hA5),
             .USE_CE(1), .CE_HIGH(1), .SRST_BEATS_CE(1)) i_cfg_flop (
    .clk_i(clk), .d_i(a_d), .q_o(q_a), .arst_i(a_arst), .srst_i(a_srst),
    .ld_i(a_ald), .ld_data_i(a_ad), .force_hi_i(a_set), .force_lo_i(a_clr),
    .ce_i(a_en));

  cfg_flop #(.WIDTH(8), .CLK_RISE(0), .USE_SRST(1), .SRST_HIGH(0),
             .SRST_INIT(8'h5A), .USE_CE(1), .CE_HIGH(0),
             .SRST_BEATS_CE(0)) i_cfg_flop_b (
    .clk_i(clk), .d_i(b_d), .q_o(q_b), .arst_i(1'b0), .srst_i(b_srst),
    .ld_i(1'b0), .ld_data_i(8'h00), .force_hi_i(8'h00), .force_lo_i(8'h00),
    .ce_i(b_en));

  cfg_flop #(.WIDTH(8), .USE_ARST(1), .ARST_HIGH(0), .ARST_INIT(8'h3C),
             .USE_CE(1), .CE_HIGH(1)) i_cfg_flop_c (
    .clk_i(clk), .d_i(c_d), .q_o(q_c), .arst_i(c_arst), .srst_i(1'b0),
    .ld_i(1'b0), .ld_data_i(8'h00), .force_hi_i(8'h00), .force_lo_i(8'h00),
    .ce_i(c_en));

  cfg_flop #(.WIDTH(8), .USE_LOAD(1), .LOAD_HIGH(1)) i_cfg_flop_d (
    .clk_i(clk), .d_i(dd_d), .q_o(q_d), .arst_i(1'b0), .srst_i(1'b0),
    .ld_i(d_ald), .ld_data_i(d_ad), .force_hi_i(8'h00), .force_lo_i(8'h00),
    .ce_i(1'b0));

  cfg_flop #(.WIDTH(8), .USE_FORCE(1), .FHI_HIGH(1), .FLO_HIGH(0),
             .USE_CE(1), .CE_HIGH(1)) i_cfg_flop_e (
    .clk_i(clk), .d_i(e_d), .q_o(q_e), .arst_i(1'b0), .srst_i(1'b0),
    .ld_i(1'b0), .ld_data_i(8'h00), .force_hi_i(e_set), .force_lo_i(e_clr),
    .ce_i(e_en));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // From a drive point (5 ns after a rising edge) past one falling and one rising edge.
  task automatic tick();
    @(negedge clk);
    @(posedge clk);
    #5;
  endtask

  task automatic t_sync_reset();
    a_srst = 1'b1; a_en = 1'b1;
    b_srst = 1'b0; b_en = 1'b0;          // both active-low -> active
    tick();
    chk("R5 A sync reset value", q_a, 8'hA5);
    chk("R5/R3 B active-low sync reset", q_b, 8'h5A);
    chk("R4/R3 C held in active-low async reset", q_c, 8'h3C);
  endtask

  task automatic t_capture();
    a_srst = 1'b0; b_srst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      a_d = 8'h10 + 8'(i * 8'h21);
      b_d = ~a_d;
      tick();
      chk("R1 A capture", q_a, a_d);
      chk("R1/R3 B capture with active-low enable", q_b, b_d);
    end
  endtask

  task automatic t_edge();
    b_d = 8'h3E;
    @(negedge clk); #2;
    chk("R2 B loads on falling edge", q_b, 8'h3E);
    b_d = 8'hC1;
    @(posedge clk); #2;
    chk("R2 B ignores rising edge", q_b, 8'h3E);
    #3;
    tick();
    chk("R2 B next falling edge", q_b, 8'hC1);
  endtask

  task automatic t_hold();
    a_en = 1'b0; b_en = 1'b1;            // both inactive
    a_d = 8'hFF; b_d = 8'h00;
    tick(); tick();
    chk("R8 A hold", q_a, 8'h52);
    chk("R8 B hold", q_b, 8'hC1);
  endtask

  task automatic t_rst_over_ce();
    a_en = 1'b0; a_srst = 1'b1;
    tick();
    chk("R6 A reset with enable off", q_a, 8'hA5);
    a_srst = 1'b0;
    tick();
    chk("R6/R8 A holds reset value", q_a, 8'hA5);
  endtask

  task automatic t_ce_over_rst();
    b_en = 1'b1; b_srst = 1'b0; b_d = 8'h99;
    tick();
    chk("R7 B reset blocked by inactive enable", q_b, 8'hC1);
    b_en = 1'b0;
    tick();
    chk("R7 B reset with enable active", q_b, 8'h5A);
    b_srst = 1'b1;
    tick();
    chk("R7 B capture after reset", q_b, 8'h99);
  endtask

  task automatic t_async_reset();
    c_arst = 1'b1; c_en = 1'b1; c_d = 8'h61;
    tick();
    chk("R4 C capture after release", q_c, 8'h61);
    c_d = 8'h62; c_arst = 1'b0;
    #2;
    chk("R4/R3 C immediate async reset", q_c, 8'h3C);
    #3;
    tick();
    chk("R4 C reset holds over edge", q_c, 8'h3C);
    c_arst = 1'b1;
    #2;
    chk("R4 C no change before edge", q_c, 8'h3C);
    #3;
    tick();
    chk("R4 C loads data after release", q_c, 8'h62);
  endtask

  task automatic t_async_load();
    d_ad = 8'h77; d_ald = 1'b1;
    #2;
    chk("R9 D load shown at once", q_d, 8'h77);
    d_ad = 8'h11;
    #1;
    chk("R9 D follows load bus", q_d, 8'h11);
    #2;
    dd_d = 8'hEE;
    tick();
    chk("R9 D load dominates edge", q_d, 8'h11);
    d_ald = 1'b0;
    #2;
    chk("R9 D keeps value after release", q_d, 8'h11);
    #3;
    tick();
    chk("R9 D captures after release", q_d, 8'hEE);
  endtask

  task automatic t_force();
    e_d = 8'hA0; e_en = 1'b1;
    tick();
    chk("R1 E capture", q_e, 8'hA0);
    e_en = 1'b0;
    e_set = 8'h0F; e_clr = ~8'h03;       // low bits 0,1 force-low, bits 0..3 force-high
    #2;
    chk("R10/R3 E per-bit force, low wins", q_e, 8'hAC);
    #3;
    tick();
    chk("R10 E force over edge", q_e, 8'hAC);
    e_set = 8'h00; e_clr = 8'hFF;
    #2;
    chk("R10 E keeps forced bits after release", q_e, 8'hAC);
    #3;
    tick();
    chk("R10/R8 E hold after release", q_e, 8'hAC);
    e_en = 1'b1; e_d = 8'h35;
    tick();
    chk("R10 E normal capture after force", q_e, 8'h35);
  endtask

  task automatic t_ignored();
    a_en = 1'b0; a_srst = 1'b0;
    a_arst = 1'b1; a_ald = 1'b1; a_ad = 8'h33; a_set = 8'hFF; a_clr = 8'hFF;
    #2;
    chk("R11 A disabled async pins no effect", q_a, 8'hA5);
    #3;
    tick();
    chk("R11 A disabled pins over edge", q_a, 8'hA5);
    a_en = 1'b1; a_d = 8'h48;
    tick();
    chk("R11 A capture with disabled pins active", q_a, 8'h48);
    a_arst = 1'b0; a_ald = 1'b0; a_ad = 8'h00; a_set = 8'h00; a_clr = 8'h00;
  endtask

  task automatic t_model();
    logic [7:0] ref_a, ref_b;
    ref_a = 8'h48;
    ref_b = 8'h99;
    for (int i = 0; i < 24; i++) begin
      automatic logic [7:0] dv = 8'(i * 29 + 3);
      automatic logic       en = (i % 3) != 0;
      automatic logic       sr = (i % 5) == 2;
      a_d = dv; a_en = en;  a_srst = sr;
      b_d = ~dv; b_en = ~en; b_srst = ~sr;
      ref_a = sr ? 8'hA5 : (en ? dv : ref_a);
      ref_b = en ? (sr ? 8'h5A : ~dv) : ref_b;
      tick();
      chk("R6/R1/R8 A vs model", q_a, ref_a);
      chk("R7/R1/R8 B vs model", q_b, ref_b);
    end
  endtask

  initial begin
    a_d = '0; a_en = 1'b1; a_srst = 1'b0; a_arst = 1'b0; a_ald = 1'b0;
    a_ad = '0; a_set = '0; a_clr = '0;
    b_d = '0; b_en = 1'b1; b_srst = 1'b1;
    c_d = '0; c_en = 1'b1; c_arst = 1'b0;
    dd_d = '0; d_ad = '0; d_ald = 1'b0;
    e_d = '0; e_en = 1'b1; e_set = '0; e_clr = 8'hFF;
    #15;
    t_sync_reset();
    t_capture();
    t_edge();
    t_hold();
    t_rst_over_ce();
    t_ce_over_rst();
    t_async_reset();
    t_async_load();
    t_force();
    t_ignored();
    t_model();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule